// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a steady train of interrupt requests for a processor core. Software programs a period, a prescale ratio and a starting count through a small register port, then sets an enable bit. A free-running prescale stage divides the clock, and each prescale expiry steps a 16-bit down-counter. When that counter runs out, the block pulses its interrupt output for one clock and reloads the counter from the period register, so the requests keep coming at a fixed rate with no software help.

The prescale register holds the divide ratio minus one, so a value of 0 steps the counter on every clock and 255 steps it once per 256 clocks. Software may overwrite the live count at any time. A new period applies from the next reload. A new prescale value restarts the prescale stage so the new rate starts cleanly. Interrupt routing, priority and masking are handled elsewhere.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the control, count, period and prescale registers all read 0 and `irq` is low.
- R2: Register map on `addr`: 0 = control (bit 0 is the enable, other bits read 0), 1 = live count, 2 = period, 3 = prescale (low 8 bits, upper bits read 0). `rdata` shows the addressed register in the same cycle.
- R3: While enabled with prescale value S, the count decrements exactly once every S+1 clocks (every clock for S = 0, every 256 clocks for S = 255).
- R4: When a decrement step finds the count at 1 (or at 0), the count is loaded from the period register on that same edge instead, and `irq` is high for exactly the one cycle in which the reloaded value first appears. Starting from count C, the first request comes C·(S+1) clocks after the enabling write edge.
- R5: After a reload from period P (P ≥ 1), the next request follows P·(S+1) clocks later, and this repeats.
- R6: With the enable bit clear, the count and the prescale phase hold their values and `irq` stays low. Setting it again resumes from the held state.
- R7: A write to the count register takes effect on its write edge and overrides any decrement or reload due on that edge.
- R8: A write to the period register leaves the live count unchanged and applies only to later reloads.
- R9: A write to the prescale register with value S' restarts the prescale stage, so the next decrement falls S'+1 clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | One-cycle interrupt request at each reload |

## Verification
The hardest state to reach from the ports is a disable that lands partway through a prescale interval, followed by a resume. The prescale phase is not readable, so the bench stops the timer at a chosen cycle and reads the held count while the timer is stopped. It then re-enables the timer and times the next request to the exact clock. That timing shows whether the prescale phase was kept. Writes that land in the same cycle as a decrement (count overwrite, period change, prescale restart) are placed by counting edges from the enabling write. The bench then checks the count one and several cycles later.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

   // register select codes; software depends on these values
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_PERIOD = 2'd2,
      SEL_SCALE  = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
   import ivl_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic [CNT_W-1:0] period_q,
   output logic [PRE_W-1:0] scale_q,
   output logic             wr_cnt,
   output logic             wr_scale,
   output logic [CNT_W-1:0] rdata
);

   localparam int PAD_W = CNT_W - PRE_W;

   logic wr_ctrl;
   logic wr_period;
   logic [CNT_W-1:0] scale_ext;

   assign wr_ctrl   = wr_en && (addr == SEL_CTRL);
   assign wr_cnt    = wr_en && (addr == SEL_COUNT);
   assign wr_period = wr_en && (addr == SEL_PERIOD);
   assign wr_scale  = wr_en && (addr == SEL_SCALE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         period_q <= '0;
         scale_q  <= '0;
      end else begin
         if (wr_ctrl)   en_q     <= wdata[CTRL_EN_BIT];
         if (wr_period) period_q <= wdata;
         if (wr_scale)  scale_q  <= wdata[PRE_W-1:0];
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign scale_ext = {{PAD_W{1'b0}}, scale_q};
      end else begin : g_nopad
         assign scale_ext = scale_q;
      end
   endgenerate

   always_comb begin
      unique case (addr)
         SEL_CTRL:   rdata = {{(CNT_W-1){1'b0}}, en_q};
         SEL_COUNT:  rdata = cnt_q;
         SEL_PERIOD: rdata = period_q;
         SEL_SCALE:  rdata = scale_ext;
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/ivl_timer_prescaler.sv
module ivl_timer_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [PRE_W-1:0] restart_val,
   input  logic [PRE_W-1:0] scale,
   output logic             tick
);

   logic [PRE_W-1:0] phase_q;
   logic             expired;

   assign expired = (phase_q == '0);
   assign tick    = en && expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= restart_val;
      end else if (en) begin
         if (expired) phase_q <= scale;
         else         phase_q <= phase_q - 1'b1;
      end
   end

endmodule

// File: rtl/ivl_timer_counter.sv
module ivl_timer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq_q
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic terminal;
   assign terminal = (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (load) begin
            cnt_q <= load_val;
         end else if (tick) begin
            if (terminal) begin
               cnt_q <= period;
               irq_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq
);

   generate
      if (PRE_W < 1 || PRE_W > CNT_W) begin : g_bad_pre
         $error("ivl_timer: PRE_W must lie in 1..CNT_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("ivl_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic             en_q;
   logic [CNT_W-1:0] period_q;
   logic [PRE_W-1:0] scale_q;
   logic             wr_cnt;
   logic             wr_scale;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   ivl_timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .cnt_q    (cnt_q),
      .en_q     (en_q),
      .period_q (period_q),
      .scale_q  (scale_q),
      .wr_cnt   (wr_cnt),
      .wr_scale (wr_scale),
      .rdata    (rdata)
   );

   ivl_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en_q),
      .restart     (wr_scale),
      .restart_val (wdata[PRE_W-1:0]),
      .scale       (scale_q),
      .tick        (tick)
   );

   ivl_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_cnt),
      .load_val (wdata),
      .period   (period_q),
      .cnt_q    (cnt_q),
      .irq_q    (irq)
   );

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [CNT_W-1:0] wdata,
   input logic             en,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic             irq
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic cnt_write;
   assign cnt_write = wr_en && (addr == ivl_timer_pkg::SEL_COUNT);

   // R1: reset drives count and request low
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (cnt == '0 && !irq));

   // R3: a step above the terminal value takes exactly one off the count
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_write && cnt > ONE) |=> cnt == $past(cnt) - ONE);

   // R4: a request always shows the freshly reloaded period
   assert_irq_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == $past(period) && $past(tick)));

   // R6: nothing moves and nothing is requested while disabled
   assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_write) |=> (cnt == $past(cnt) && !irq));

   // R7: a count write lands on its own edge
   assert_count_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_write |=> (cnt == $past(wdata) && !irq));

endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .en     (en_q),
   .tick   (tick),
   .cnt    (cnt_q),
   .period (period_q),
   .irq    (irq)
);

// File: tb/ivl_timer_test.sv
module ivl_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ivl_timer uut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .irq   (irq)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge; returns at the following negedge
   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   // counts edges after the caller's current negedge until irq is seen
   task automatic wait_irq(input int max, output int found);
      found = -1;
      addr = 2'd1;
      for (int j = 1; j <= max; j++) begin
         @(negedge clk);
         if (irq) begin
            found = j;
            break;
         end
      end
   endtask

   task automatic setup(input int s, input int p, input int c);
      wr(2'd0, 16'd0);
      wr(2'd3, 16'(s));
      wr(2'd2, 16'(p));
      wr(2'd1, 16'(c));
   endtask

   task automatic t_reset;
      int v;
      rd(2'd0, v); check_eq("R1", "ctrl after reset", v, 0);
      rd(2'd1, v); check_eq("R1", "count after reset", v, 0);
      rd(2'd2, v); check_eq("R1", "period after reset", v, 0);
      rd(2'd3, v); check_eq("R1", "prescale after reset", v, 0);
      check_eq("R1", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_readback;
      int v;
      wr(2'd2, 16'h1234);
      wr(2'd3, 16'h01AB);
      wr(2'd1, 16'hBEEF);
      wr(2'd0, 16'hFFFE);
      rd(2'd2, v); check_eq("R2", "period readback", v, 16'h1234);
      rd(2'd3, v); check_eq("R2", "prescale keeps low 8 bits", v, 16'h00AB);
      rd(2'd1, v); check_eq("R7", "count write readback", v, 16'hBEEF);
      rd(2'd0, v); check_eq("R2", "ctrl with enable bit clear", v, 0);
      wr(2'd0, 16'h0001);
      rd(2'd0, v); check_eq("R2", "ctrl with enable bit set", v, 1);
      wr(2'd0, 16'h0000);
   endtask

   // R3 R4 R5: first request at C*(S+1), then every P*(S+1)
   task automatic t_periodic(input int s, input int p, input int c);
      int j, v;
      setup(s, p, c);
      wr(2'd0, 16'd1);
      wait_irq(c * (s + 1) + 10, j);
      check_eq("R3", $sformatf("first irq cycle S=%0d C=%0d", s, c), j, c * (s + 1));
      rd(2'd1, v);
      check_eq("R4", "count reloaded from period at irq", v, p);
      @(negedge clk);
      check_eq("R4", "irq lasts one cycle", int'(irq), 0);
      wait_irq(p * (s + 1) + 10, j);
      check_eq("R5", $sformatf("irq interval S=%0d P=%0d", s, p), j + 1, p * (s + 1));
      wr(2'd0, 16'd0);
   endtask

   task automatic t_disable_r6;
      int j, v, held, seen;
      setup(1, 10, 10);
      wr(2'd0, 16'd1);
      repeat (5) @(negedge clk);
      wr(2'd0, 16'd0);
      rd(2'd1, held);
      check_eq("R6", "count at disable", held, 7);
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (irq) seen++;
      end
      rd(2'd1, v);
      check_eq("R6", "count held while disabled", v, held);
      check_eq("R6", "no irq while disabled", seen, 0);
      wr(2'd0, 16'd1);
      wait_irq(40, j);
      check_eq("R6", "resume keeps prescale phase", j, held * 2);
      wr(2'd0, 16'd0);
   endtask

   task automatic t_count_write_r7;
      int j, v;
      setup(0, 100, 50);
      wr(2'd0, 16'd1);
      repeat (3) @(negedge clk);
      wr(2'd1, 16'd4);
      rd(2'd1, v);
      check_eq("R7", "count write beats same-edge decrement", v, 4);
      wait_irq(20, j);
      check_eq("R7", "irq timed from written count", j, 4);
      wr(2'd0, 16'd0);
   endtask

   task automatic t_period_r8;
      int j, v;
      setup(0, 3, 6);
      wr(2'd0, 16'd1);
      repeat (2) @(negedge clk);
      wr(2'd2, 16'd9);
      rd(2'd1, v);
      check_eq("R8", "period write leaves live count", v, 3);
      rd(2'd2, v);
      check_eq("R8", "new period stored", v, 9);
      wait_irq(20, j);
      check_eq("R8", "current run ends on old count", j, 3);
      rd(2'd1, v);
      check_eq("R8", "reload uses new period", v, 9);
      wait_irq(30, j);
      check_eq("R8", "interval follows new period", j, 9);
      wr(2'd0, 16'd0);
   endtask

   task automatic t_prescale_r9;
      int v;
      setup(7, 50, 50);
      wr(2'd0, 16'd1);
      repeat (3) @(negedge clk);
      wr(2'd3, 16'd2);
      addr = 2'd1;
      @(negedge clk);
      #1 v = int'(rdata);
      check_eq("R9", "no step one cycle after restart", v, 50);
      @(negedge clk);
      #1 v = int'(rdata);
      check_eq("R9", "no step two cycles after restart", v, 50);
      @(negedge clk);
      #1 v = int'(rdata);
      check_eq("R9", "first step at new rate", v, 49);
      repeat (3) @(negedge clk);
      #1 v = int'(rdata);
      check_eq("R9", "second step at new rate", v, 48);
      wr(2'd0, 16'd0);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_periodic(0, 5, 3);
      t_periodic(2, 3, 4);
      t_periodic(255, 1, 2);
      t_disable_r6();
      t_count_write_r7();
      t_period_r8();
      t_prescale_r9();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule